// File: doc/BRIEF.md
# LAPD Control Field Protocol Checker

This block examines every received data-link frame once its address and control octets have been parsed and its length is known, and decides whether the frame breaks the acknowledged-transfer rules for the current link state. It runs only while the controller performs automatic acknowledgement handling. In that mode it reports four kinds of violation:
- an acknowledgement number outside the outstanding window;
- a supervisory frame that carries payload;
- an information frame received as a response;
- a supervisory frame with a control encoding that has no defined meaning.

Frames already known to be corrupt, meaning a failed check sequence or an abort, are ignored. The result is a single-cycle error pulse with a two-bit cause code. Interrupt logging and link recovery are left to the surrounding logic.

Each checked frame is presented for one cycle on `frm_valid`, together with the local send state variable and the oldest unacknowledged sequence number. The checker holds no per-link state of its own. Sequence arithmetic is modulo 128 for two-octet control fields and modulo 8 for one-octet fields.

Top module: `lapd_pe_check`

## Requirements
- R1: A check happens only in a cycle where `frm_valid`=1, `frm_good`=1 and `auto_mode`=1. Its result appears on `pe_pulse`/`pe_cause` after exactly one clock edge and lasts one cycle. While `pe_pulse`=0, `pe_cause` is 0. After reset, `pe_pulse`=0 and `pe_cause`=0.
- R2: While `auto_mode`=0, no frame ever raises `pe_pulse`.
- R3: A frame presented with `frm_good`=0 never raises `pe_pulse`.
- R4: With `ext_mode`=1, frame type comes from the bits of `ctrl_lo`. Bit0=0 means an information (I) frame. Bits[1:0]=01 means a supervisory (S) frame, with the supervisory code in bits[3:2]. Bits[1:0]=11 means an unnumbered frame. For I and S frames, N(R) is `ctrl_hi[7:1]` and `ctrl_hi[0]` is ignored. N(R) is accepted when (N(R)−`va`) mod 128 ≤ (`vs`−`va`) mod 128. Otherwise the frame gets cause 0.
- R5: With `ext_mode`=0, N(R) is `ctrl_lo[7:5]` and the supervisory code is `ctrl_lo[3:2]`. Only the low 3 bits of `vs`/`va` count, and the window test of R4 is applied modulo 8.
- R6: An S frame with `info_len`≠0 gets cause 1.
- R7: An I frame that is not a command gets cause 2. On the user side (`net_side`=0) a received command has `cr_bit`=1. On the network side (`net_side`=1) a received command has `cr_bit`=0.
- R8: An S frame with supervisory code 11 gets cause 3. In extended mode, an S frame with any of `ctrl_lo[7:4]` set also gets cause 3.
- R9: Unnumbered frames never raise an error.
- R10: When several violations apply, the cause reported follows the priority 3 > 1 > 2 > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mode | input | 1 | Automatic acknowledgement mode active |
| net_side | input | 1 | 1 when this end is the network side |
| ext_mode | input | 1 | 1 for two-octet control fields (modulo 128) |
| frm_valid | input | 1 | Parsed frame presented this cycle |
| frm_good | input | 1 | Frame passed its check sequence and was not aborted |
| cr_bit | input | 1 | Command/response bit from the address field |
| ctrl_lo | input | 8 | First control octet |
| ctrl_hi | input | 8 | Second control octet (extended mode) |
| info_len | input | 11 | Information field length in octets |
| vs | input | 7 | Send state variable |
| va | input | 7 | Acknowledge state variable |
| pe_pulse | output | 1 | One-cycle protocol error pulse |
| pe_cause | output | 2 | Error cause: 0 bad N(R), 1 S with info, 2 I not command, 3 undefined S |

## Verification
The hardest situations to reach are frames where several violations coincide, and N(R) values that sit exactly on a window edge after the counters have wrapped past zero. The vector table drives both directly. It includes windows where `va` is above `vs`, such as 126 to 2 modulo 128 and 6 to 1 modulo 8. It also includes frames that combine payload, a reserved code and a bad N(R), so that only the priority rule decides the cause.

// File: rtl/lapd_pe_pkg.sv
package lapd_pe_pkg;

  localparam int SEQ_W = 7;

  typedef enum logic [1:0] {
    PE_BAD_NR  = 2'd0,
    PE_S_INFO  = 2'd1,
    PE_I_RSP   = 2'd2,
    PE_S_UNDEF = 2'd3
  } pe_cause_e;

  typedef enum logic [1:0] {
    FT_I = 2'd0,
    FT_S = 2'd1,
    FT_U = 2'd2
  } frm_type_e;

  // distance from base to pos walking forward, reduced by mask
  function automatic logic [SEQ_W-1:0] seq_dist(
    input logic [SEQ_W-1:0] pos,
    input logic [SEQ_W-1:0] base,
    input logic [SEQ_W-1:0] mask
  );
    return (pos - base) & mask;
  endfunction

  function automatic logic nr_in_window(
    input logic [SEQ_W-1:0] nr,
    input logic [SEQ_W-1:0] va,
    input logic [SEQ_W-1:0] vs,
    input logic [SEQ_W-1:0] mask
  );
    return seq_dist(nr, va, mask) <= seq_dist(vs, va, mask);
  endfunction

endpackage

// File: rtl/lapd_ctl_decode.sv
module lapd_ctl_decode
  import lapd_pe_pkg::*;
(
  input  logic             ext_mode,
  input  logic [7:0]       ctrl_lo,
  input  logic [7:0]       ctrl_hi,
  output frm_type_e        ftype,
  output logic [SEQ_W-1:0] nr,
  output logic [1:0]       s_code,
  output logic             s_rsv_set
);

  always_comb begin
    if (!ctrl_lo[0])            ftype = FT_I;
    else if (ctrl_lo[1] == 1'b0) ftype = FT_S;
    else                        ftype = FT_U;
  end

  assign s_code = ctrl_lo[3:2];

  always_comb begin
    if (ext_mode) begin
      nr        = ctrl_hi[7:1];
      s_rsv_set = |ctrl_lo[7:4];
    end else begin
      nr        = {{(SEQ_W-3){1'b0}}, ctrl_lo[7:5]};
      s_rsv_set = 1'b0;
    end
  end

endmodule

// File: rtl/lapd_nr_window.sv
module lapd_nr_window
  import lapd_pe_pkg::*;
#(
  parameter int EXT_BITS   = SEQ_W,
  parameter int BASIC_BITS = 3
) (
  input  logic             ext_mode,
  input  logic [SEQ_W-1:0] nr,
  input  logic [SEQ_W-1:0] va,
  input  logic [SEQ_W-1:0] vs,
  output logic             nr_ok
);

  localparam logic [SEQ_W-1:0] EXT_MASK   = SEQ_W'((1 << EXT_BITS) - 1);
  localparam logic [SEQ_W-1:0] BASIC_MASK = SEQ_W'((1 << BASIC_BITS) - 1);

  logic [SEQ_W-1:0] mask;

  assign mask  = ext_mode ? EXT_MASK : BASIC_MASK;
  assign nr_ok = nr_in_window(nr, va, vs, mask);

endmodule

// File: rtl/lapd_pe_check.sv
module lapd_pe_check
  import lapd_pe_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic             net_side,
  input  logic             ext_mode,
  input  logic             frm_valid,
  input  logic             frm_good,
  input  logic             cr_bit,
  input  logic [7:0]       ctrl_lo,
  input  logic [7:0]       ctrl_hi,
  input  logic [LEN_W-1:0] info_len,
  input  logic [SEQ_W-1:0] vs,
  input  logic [SEQ_W-1:0] va,
  output logic             pe_pulse,
  output logic [1:0]       pe_cause
);

  frm_type_e        ftype;
  logic [SEQ_W-1:0] nr;
  logic [1:0]       s_code;
  logic             s_rsv_set;
  logic             nr_ok;

  // named events for the checker
  logic ev_check, ev_undef, ev_s_info, ev_i_rsp, ev_bad_nr, ev_any;
  logic is_cmd;
  pe_cause_e cause_nxt;

  lapd_ctl_decode u_dec (
    .ext_mode (ext_mode),
    .ctrl_lo  (ctrl_lo),
    .ctrl_hi  (ctrl_hi),
    .ftype    (ftype),
    .nr       (nr),
    .s_code   (s_code),
    .s_rsv_set(s_rsv_set)
  );

  lapd_nr_window u_win (
    .ext_mode(ext_mode),
    .nr      (nr),
    .va      (va),
    .vs      (vs),
    .nr_ok   (nr_ok)
  );

  assign ev_check  = frm_valid & frm_good & auto_mode;
  assign is_cmd    = cr_bit ^ net_side;
  assign ev_undef  = (ftype == FT_S) && ((s_code == 2'b11) || s_rsv_set);
  assign ev_s_info = (ftype == FT_S) && (info_len != '0);
  assign ev_i_rsp  = (ftype == FT_I) && !is_cmd;
  assign ev_bad_nr = (ftype != FT_U) && !nr_ok;
  assign ev_any    = ev_undef | ev_s_info | ev_i_rsp | ev_bad_nr;

  always_comb begin
    if (ev_undef)       cause_nxt = PE_S_UNDEF;
    else if (ev_s_info) cause_nxt = PE_S_INFO;
    else if (ev_i_rsp)  cause_nxt = PE_I_RSP;
    else                cause_nxt = PE_BAD_NR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_pulse <= 1'b0;
      pe_cause <= 2'd0;
    end else if (ev_check && ev_any) begin
      pe_pulse <= 1'b1;
      pe_cause <= cause_nxt;
    end else begin
      pe_pulse <= 1'b0;
      pe_cause <= 2'd0;
    end
  end

endmodule

// File: rtl/lapd_pe_check_sva.sv
module lapd_pe_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_mode,
  input logic       frm_valid,
  input logic       frm_good,
  input logic       ftype_u,
  input logic       ev_undef,
  input logic       ev_s_info,
  input logic       pe_pulse,
  input logic [1:0] pe_cause
);

  AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_pulse |-> pe_cause == 2'd0); // R1

  AST_PULSE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    pe_pulse |-> $past(frm_valid)); // R1

  AST_MANUAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pe_pulse |-> $past(auto_mode)); // R2

  AST_BAD_FRAME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pe_pulse |-> $past(frm_good)); // R3

  AST_UNNUMBERED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && ftype_u) |=> !pe_pulse); // R9

  AST_UNDEF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_good && auto_mode && ev_undef) |=> (pe_pulse && pe_cause == 2'd3)); // R8

  AST_SINFO_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_good && auto_mode && ev_s_info && !ev_undef) |=> (pe_pulse && pe_cause == 2'd1)); // R10

endmodule

bind lapd_pe_check lapd_pe_check_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .auto_mode(auto_mode),
  .frm_valid(frm_valid),
  .frm_good (frm_good),
  .ftype_u  (ftype == lapd_pe_pkg::FT_U),
  .ev_undef (ev_undef),
  .ev_s_info(ev_s_info),
  .pe_pulse (pe_pulse),
  .pe_cause (pe_cause)
);

// File: tb/lapd_pe_check_test.sv
module lapd_pe_check_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auto_mode = 1'b0, net_side = 1'b0, ext_mode = 1'b0;
  logic        frm_valid = 1'b0, frm_good = 1'b0, cr_bit = 1'b0;
  logic [7:0]  ctrl_lo = '0, ctrl_hi = '0;
  logic [10:0] info_len = '0;
  logic [6:0]  vs = '0, va = '0;
  logic        pe_pulse;
  logic [1:0]  pe_cause;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lapd_pe_check uut (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .net_side(net_side),
    .ext_mode(ext_mode), .frm_valid(frm_valid), .frm_good(frm_good),
    .cr_bit(cr_bit), .ctrl_lo(ctrl_lo), .ctrl_hi(ctrl_hi), .info_len(info_len),
    .vs(vs), .va(va), .pe_pulse(pe_pulse), .pe_cause(pe_cause)
  );

  // {ext,net,cr,lo,hi,len,vs,va,exp_pe,exp_cause} = 44 bits
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1, 8'h00, 8'h0A, 8'd10, 7'd7,  7'd3,  1'b0, 2'd0}, // R4 I cmd nr5 in [3,7]
    {1'b1,1'b0,1'b1, 8'h00, 8'h10, 8'd10, 7'd7,  7'd3,  1'b1, 2'd0}, // R4 nr8 outside
    {1'b1,1'b0,1'b1, 8'h00, 8'h0B, 8'd4,  7'd7,  7'd3,  1'b0, 2'd0}, // R4 P/F bit ignored
    {1'b1,1'b0,1'b1, 8'h00, 8'h06, 8'd4,  7'd7,  7'd3,  1'b0, 2'd0}, // R4 nr=va edge
    {1'b1,1'b0,1'b1, 8'h00, 8'h04, 8'd4,  7'd7,  7'd3,  1'b1, 2'd0}, // R4 nr=va-1
    {1'b1,1'b0,1'b0, 8'h00, 8'h0A, 8'd10, 7'd7,  7'd3,  1'b1, 2'd2}, // R7 I response user side
    {1'b1,1'b0,1'b0, 8'h01, 8'h06, 8'd0,  7'd7,  7'd3,  1'b0, 2'd0}, // R4 S RR ok
    {1'b1,1'b0,1'b1, 8'h05, 8'h06, 8'd4,  7'd7,  7'd3,  1'b1, 2'd1}, // R6 RNR with info
    {1'b1,1'b0,1'b1, 8'h0D, 8'h06, 8'd0,  7'd7,  7'd3,  1'b1, 2'd3}, // R8 code 11
    {1'b1,1'b0,1'b1, 8'h11, 8'h06, 8'd0,  7'd7,  7'd3,  1'b1, 2'd3}, // R8 reserved bit
    {1'b1,1'b0,1'b1, 8'h00, 8'h00, 8'd1,  7'd2,  7'd126,1'b0, 2'd0}, // R4 wrap nr0
    {1'b1,1'b0,1'b1, 8'h00, 8'h06, 8'd1,  7'd2,  7'd126,1'b1, 2'd0}, // R4 wrap nr3
    {1'b1,1'b0,1'b0, 8'h7F, 8'hFF, 8'd5,  7'd0,  7'd0,  1'b0, 2'd0}, // R9 U frame
    {1'b0,1'b0,1'b1, 8'h42, 8'hFF, 8'd3,  7'd3,  7'd1,  1'b0, 2'd0}, // R5 nr2 in [1,3]
    {1'b0,1'b0,1'b1, 8'hA2, 8'h00, 8'd3,  7'd3,  7'd1,  1'b1, 2'd0}, // R5 nr5 out
    {1'b0,1'b0,1'b1, 8'h29, 8'h00, 8'd0,  7'd9,  7'd1,  1'b0, 2'd0}, // R5 REJ, upper vs bits ignored
    {1'b0,1'b0,1'b1, 8'hE0, 8'h00, 8'd2,  7'd1,  7'd6,  1'b0, 2'd0}, // R5 wrap nr7
    {1'b0,1'b1,1'b0, 8'h40, 8'h00, 8'd2,  7'd1,  7'd6,  1'b1, 2'd0}, // R5 wrap nr2 out, net cmd
    {1'b1,1'b1,1'b1, 8'h00, 8'h0A, 8'd2,  7'd7,  7'd3,  1'b1, 2'd2}, // R7 net side cr=1 response
    {1'b1,1'b0,1'b1, 8'h01, 8'h7E, 8'd3,  7'd7,  7'd3,  1'b1, 2'd1}, // R10 S info beats bad nr
    {1'b1,1'b0,1'b0, 8'h00, 8'h7E, 8'd3,  7'd7,  7'd3,  1'b1, 2'd2}  // R10 I rsp beats bad nr
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pe/cause actual=%0b/%0d expected=%0b/%0d",
               req, act[2], act[1:0], exp[2], exp[1:0]);
    end
  endtask

  task automatic present(input logic e, input logic n, input logic c, input logic [7:0] lo,
                         input logic [7:0] hi, input logic [10:0] len,
                         input logic [6:0] s, input logic [6:0] a, input logic good);
    @(negedge clk);
    ext_mode = e; net_side = n; cr_bit = c; ctrl_lo = lo; ctrl_hi = hi;
    info_len = len; vs = s; va = a; frm_good = good; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {pe_pulse, pe_cause}, 3'b000);
    rst_n = 1'b1;
    auto_mode = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      present(v[43], v[42], v[41], v[40:33], v[32:25], {3'b0, v[24:17]},
              v[16:10], v[9:3], 1'b1);
      check($sformatf("R4-R10 vector %0d", i), {pe_pulse, pe_cause}, v[2:0]);
    end

    // R1: pulse lasts one cycle, cause returns to 0
    present(1'b1, 1'b0, 1'b1, 8'h0D, 8'h06, 11'd0, 7'd7, 7'd3, 1'b1);
    check("R1 pulse", {pe_pulse, pe_cause}, 3'b111);
    @(negedge clk);
    check("R1 one cycle", {pe_pulse, pe_cause}, 3'b000);

    // R10: undefined beats info and bad nr
    present(1'b1, 1'b0, 1'b1, 8'h0D, 8'h7E, 11'd300, 7'd7, 7'd3, 1'b1);
    check("R10 undef first", {pe_pulse, pe_cause}, 3'b111);

    // R6 with wide length
    present(1'b1, 1'b0, 1'b1, 8'h09, 8'h06, 11'd1024, 7'd7, 7'd3, 1'b1);
    check("R6 long info", {pe_pulse, pe_cause}, 3'b101);

    // R3: bad frame ignored
    present(1'b1, 1'b0, 1'b0, 8'h0D, 8'h7E, 11'd5, 7'd7, 7'd3, 1'b0);
    check("R3 bad crc", {pe_pulse, pe_cause}, 3'b000);

    // R2: manual mode ignored
    auto_mode = 1'b0;
    present(1'b1, 1'b0, 1'b0, 8'h0D, 8'h7E, 11'd5, 7'd7, 7'd3, 1'b1);
    check("R2 manual", {pe_pulse, pe_cause}, 3'b000);
    auto_mode = 1'b1;

    // R1: no valid strobe, no result
    @(negedge clk);
    ctrl_lo = 8'h0D; frm_good = 1'b1;
    @(negedge clk);
    check("R1 no strobe", {pe_pulse, pe_cause}, 3'b000);

    // R1: back-to-back frames give back-to-back results
    @(negedge clk);
    ext_mode = 1'b1; net_side = 1'b0; cr_bit = 1'b0; ctrl_lo = 8'h00; ctrl_hi = 8'h0A;
    info_len = 11'd1; vs = 7'd7; va = 7'd3; frm_valid = 1'b1;
    @(negedge clk);
    check("R1 first of pair", {pe_pulse, pe_cause}, 3'b110);
    cr_bit = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    check("R1 second of pair", {pe_pulse, pe_cause}, 3'b000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule